// File: doc/BRIEF.md
# Bitmap Framebuffer Pixel Scanout

This block reads a one-bit-per-pixel bitmap out of an external word-addressed frame memory and turns it into a serial pixel stream in raster order. Each memory word carries sixteen horizontally adjacent pixels. The block consumes them least significant bit first, so the leftmost pixel of a group comes from bit 0. Rows are laid out back to back: a row of 512 pixels takes 32 consecutive words, and the top-left pixel sits in bit 0 of word 0.

The block drives the read port of the memory: a read strobe with a word address. It expects the word on the data input one clock later. It keeps a two-word buffer so that the next word is already on hand when the current one runs out. A consumer steps through the frame one pixel at a time with a pixel-enable input. Alongside each pixel the block presents its row and column, plus markers for the first pixel of a line and the first pixel of a frame. Display timing, writes into the memory and colour mapping belong to other blocks.

Top module: `bitmap_scanout`

## Requirements
- R1: While `pix_valid` is high, `pix` equals bit `col % WORD_W` of memory word `row * (COLS / WORD_W) + col / WORD_W`. The defaults are 256 rows, 512 columns and 16-bit words, which gives 32 words per row and a 13-bit word address.
- R2: Within one word, pixels go out least significant bit first. Bit 0 supplies the leftmost column of the group of `WORD_W` columns.
- R3: A clock edge that samples `pix_en` and `pix_valid` both high advances `col` by one. From `COLS-1` the column wraps to 0 and `row` advances.
- R4: `row` wraps from `ROWS-1` to 0 when the last column of the last row is consumed, and the frame then starts again from word 0.
- R5: A clock edge without an accepted pixel (`pix_en` low or `pix_valid` low) leaves `row`, `col` and `pix` unchanged.
- R6: `line_start` is high exactly while `pix_valid` is high and `col` is 0.
- R7: `frame_start` is high exactly while `pix_valid` is high and both `row` and `col` are 0.
- R8: Each cycle with `rd_en` high requests the word at `rd_addr`, and the memory returns it on `rd_data` one clock later. After reset the requests run 0, 1, 2, … and wrap to 0 after word `ROWS*COLS/WORD_W - 1`. Two requests are never issued in consecutive cycles.
- R9: `pix_valid` rises by the third rising edge after reset is released. After that it stays high, including while `pix_en` is held high on every cycle.
- R10: `rst_n` is a synchronous, active-low reset. It sets `row` and `col` to 0, drops `pix_valid` and discards any words already fetched. The first pixel after release comes from word 0 as the memory holds it after the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Advance the scan by one pixel |
| rd_en | output | 1 | Frame memory read strobe |
| rd_addr | output | ADDR_W | Frame memory word address |
| rd_data | input | WORD_W | Word returned one clock after the strobe |
| pix | output | 1 | Current pixel value |
| pix_valid | output | 1 | Current pixel, row and column are meaningful |
| row | output | ROW_W | Row of the current pixel |
| col | output | COL_W | Column of the current pixel |
| line_start | output | 1 | Current pixel is column 0 |
| frame_start | output | 1 | Current pixel is row 0, column 0 |

## Verification
The bench runs a reduced configuration (4 rows of 64 columns) through two whole frames for each memory pattern: two isolated set bits, walking ones, alternating all-ones rows and a hashed fill. Every pixel is compared against the addressing rule. A design with the bit order reversed would put the isolated bit at column 24 instead of column 23. A design with an off-by-one word pointer would shift whole 16-pixel groups, and both would also disturb the all-ones row edges. Enable patterns with gaps catch a scan that advances on an idle cycle or changes the pixel while holding. Continuous enables catch a prefetch that arrives late and makes `pix_valid` drop at a word boundary. A reset in the middle of a frame, with the memory inverted while reset is held, shows whether a stale prefetched word leaks into the first pixels of the new frame.

// File: rtl/fb_scan_pkg.sv
// Shared helpers for the bitmap scanout block.
// Assumes: all counts passed in are positive.
package fb_scan_pkg;

    // Index width for a counter covering 0..n-1; never narrower than one bit.
    function automatic int idx_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/scan_counter.sv
// Row/column raster counter.
// Steps one column per accepted pixel, wraps the column into the next row
// and the last row back to row 0.
// Assumes: ROWS and COLS fit into ROW_W and COL_W bits.
module scan_counter #(
    parameter int ROWS  = 256,
    parameter int COLS  = 512,
    parameter int ROW_W = 8,
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

    // Raster position update with column and row wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
            col <= '0;
        end else if (step) begin
            if (col == COL_LAST) begin
                col <= '0;
                row <= (row == ROW_LAST) ? '0 : row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end
endmodule

// File: rtl/word_fetch.sv
// Frame memory read sequencer.
// Issues a read whenever the buffer asks for a word and no read is in flight.
// Addresses run linearly through the frame and wrap after the last word.
// Assumes: the memory returns data exactly one clock after the strobe.
module word_fetch #(
    parameter int N_WORDS = 8192,
    parameter int ADDR_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              want,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              arrive
);
    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(N_WORDS - 1);

    logic [ADDR_W-1:0] addr_q;
    logic              pending_q;

    assign rd_en   = want && !pending_q;
    assign rd_addr = addr_q;
    assign arrive  = pending_q;

    // Track the in-flight read and advance the linear word pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            pending_q <= 1'b0;
        end else begin
            pending_q <= rd_en;
            if (rd_en) begin
                addr_q <= (addr_q == ADDR_LAST) ? '0 : addr_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pixel_buffer.sv
// Two-slot word buffer: the current word being shifted out and the next
// word prefetched behind it.
// Asks for a new word whenever the next slot is empty or is being emptied.
// Assumes: an arriving word always finds the next slot empty.
module pixel_buffer #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arrive,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              consume,
    output logic [WORD_W-1:0] cur_word,
    output logic              cur_valid,
    output logic              want
);
    logic [WORD_W-1:0] nxt_word;
    logic              nxt_valid;
    logic              load_cur;

    assign load_cur = (!cur_valid && nxt_valid) || consume;
    assign want     = !nxt_valid || load_cur;

    // Move the prefetched word forward and capture returning read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_word  <= '0;
            cur_valid <= 1'b0;
            nxt_word  <= '0;
            nxt_valid <= 1'b0;
        end else begin
            if (load_cur) begin
                cur_word  <= nxt_word;
                cur_valid <= nxt_valid;
            end
            if (arrive) begin
                nxt_word  <= rd_data;
                nxt_valid <= 1'b1;
            end else if (load_cur) begin
                nxt_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bitmap_scanout.sv
// Bitmap framebuffer scanout.
// Walks a packed one-bit-per-pixel frame in raster order, LSB first within
// each memory word, and presents one pixel per accepted pixel enable.
// Assumes: COLS is a multiple of WORD_W, WORD_W is a power of two, and the
// frame memory has a fixed one-clock read latency.
module bitmap_scanout #(
    parameter int ROWS   = 256,
    parameter int COLS   = 512,
    parameter int WORD_W = 16,
    parameter int ROW_W  = fb_scan_pkg::idx_width(ROWS),
    parameter int COL_W  = fb_scan_pkg::idx_width(COLS),
    parameter int ADDR_W = fb_scan_pkg::idx_width(ROWS * (COLS / WORD_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              pix,
    output logic              pix_valid,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic              line_start,
    output logic              frame_start
);
    localparam int N_WORDS = ROWS * (COLS / WORD_W);
    localparam int BIT_W   = fb_scan_pkg::idx_width(WORD_W);

    logic              step;
    logic              consume;
    logic              word_end;
    logic              arrive;
    logic              want;
    logic [WORD_W-1:0] cur_word;
    logic              cur_valid;

    assign step    = pix_en && cur_valid;
    assign consume = step && word_end;

    // Bit select within the current word; one-bit words need no index.
    if (WORD_W == 1) begin : g_bitwide
        assign word_end = 1'b1;
        assign pix      = cur_word[0];
    end else begin : g_packed
        logic [BIT_W-1:0] bit_sel;
        assign bit_sel  = col[BIT_W-1:0];
        assign word_end = (bit_sel == BIT_W'(WORD_W - 1));
        assign pix      = cur_word[bit_sel];
    end

    assign pix_valid   = cur_valid;
    assign line_start  = cur_valid && (col == '0);
    assign frame_start = line_start && (row == '0);

    scan_counter #(
        .ROWS (ROWS),
        .COLS (COLS),
        .ROW_W(ROW_W),
        .COL_W(COL_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .step (step),
        .row  (row),
        .col  (col)
    );

    word_fetch #(
        .N_WORDS(N_WORDS),
        .ADDR_W (ADDR_W)
    ) u_fetch (
        .clk    (clk),
        .rst_n  (rst_n),
        .want   (want),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .arrive (arrive)
    );

    pixel_buffer #(
        .WORD_W(WORD_W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .arrive   (arrive),
        .rd_data  (rd_data),
        .consume  (consume),
        .cur_word (cur_word),
        .cur_valid(cur_valid),
        .want     (want)
    );
endmodule

// File: rtl/fb_scan_chk.sv
// Property checker for bitmap_scanout, attached by bind below.
// Assumes: the memory model honours the one-clock read latency.
module fb_scan_chk #(
    parameter int ROWS    = 256,
    parameter int COLS    = 512,
    parameter int ROW_W   = 8,
    parameter int COL_W   = 9,
    parameter int ADDR_W  = 13,
    parameter int N_WORDS = 8192
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              pix_valid,
    input logic [ROW_W-1:0]  row,
    input logic [COL_W-1:0]  col,
    input logic              line_start,
    input logic              frame_start
);
    localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(COLS - 1);
    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(N_WORDS - 1);

    logic              seen_q;
    logic [ADDR_W-1:0] last_q;
    logic [ADDR_W-1:0] want_addr;

    // Remember the previous requested address to check the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (rd_en) begin
            seen_q <= 1'b1;
            last_q <= rd_addr;
        end
    end

    assign want_addr = (last_q == ADDR_LAST) ? '0 : last_q + 1'b1;

    AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n) col <= COL_LAST); // R3
    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n) row <= ROW_LAST); // R4
    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && pix_valid && col != COL_LAST) |=> (col == $past(col) + 1'b1) && $stable(row)); // R3
    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && pix_valid && col == COL_LAST && row == ROW_LAST) |=> (row == '0 && col == '0)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_en && pix_valid) |=> ($stable(row) && $stable(col))); // R5
    AST_LINE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && pix_valid && col == COL_LAST) |=> line_start); // R6
    AST_FRAME_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && pix_valid && col == COL_LAST && row == ROW_LAST) |=> frame_start); // R7
    AST_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> !rd_en); // R8
    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !seen_q) |-> (rd_addr == '0)); // R8
    AST_ADDR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && seen_q) |-> (rd_addr == want_addr)); // R8
    AST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n) pix_valid |=> pix_valid); // R9
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (row == '0 && col == '0 && !pix_valid)); // R10
endmodule

bind bitmap_scanout fb_scan_chk #(
    .ROWS   (ROWS),
    .COLS   (COLS),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .ADDR_W (ADDR_W),
    .N_WORDS(N_WORDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_en     (pix_en),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .pix_valid  (pix_valid),
    .row        (row),
    .col        (col),
    .line_start (line_start),
    .frame_start(frame_start)
);

// File: tb/sim_bitmap_scanout.sv
// Bench for bitmap_scanout on a reduced frame: 4 rows x 64 columns,
// 16-bit words. Expected pixels come from the addressing rule.
module sim_bitmap_scanout;
    localparam int ROWS = 4;
    localparam int COLS = 64;
    localparam int WW   = 16;
    localparam int WPR  = COLS / WW;
    localparam int NW   = ROWS * WPR;
    localparam int AW   = 4;
    localparam int RW   = 2;
    localparam int CW   = 6;
    localparam int FRAME = ROWS * COLS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_en = 1'b0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [WW-1:0] rd_data = '0;
    logic          pix, pix_valid, line_start, frame_start;
    logic [RW-1:0] row;
    logic [CW-1:0] col;

    logic [WW-1:0] mem [NW];

    int n_chk = 0, n_fail = 0;
    int mr = 0, mc = 0;
    int exp_addr = 0;
    bit prev_rd = 0;
    bit last_en = 1, have_prev = 0;
    int prev_row, prev_col, prev_pix;
    int ones = 0, one_r = -1, one_c = -1;
    bit done = 0;

    always #10 clk = ~clk;

    bitmap_scanout #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .pix(pix), .pix_valid(pix_valid),
        .row(row), .col(col), .line_start(line_start), .frame_start(frame_start)
    );

    // Behavioural frame memory with one clock of read latency.
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_pix(input int r, input int c);
        return int'(mem[r * WPR + c / WW][c % WW]);
    endfunction

    // One cycle: observe at the falling edge, then drive the next inputs.
    task automatic tick(input bit en, input bit rv, input bit chk);
        @(negedge clk);
        if (!rv) begin
            exp_addr = 0;
            prev_rd  = 0;
        end else begin
            if (rd_en) begin
                check(!prev_rd, "R8 back-to-back read", 1, 0);
                check(int'(rd_addr) == exp_addr, "R8 read address", int'(rd_addr), exp_addr);
                exp_addr = (exp_addr + 1) % NW;
            end
            prev_rd = rd_en;
        end
        if (chk) begin
            check(pix_valid == 1'b1, "R9 pixel stream stalled", int'(pix_valid), 1);
            check(int'(pix) == exp_pix(mr, mc), "R1 R2 pixel value", int'(pix), exp_pix(mr, mc));
            check(int'(col) == mc, "R3 column", int'(col), mc);
            check(int'(row) == mr, "R4 row", int'(row), mr);
            check(int'(line_start) == int'(mc == 0), "R6 line_start", int'(line_start), int'(mc == 0));
            check(int'(frame_start) == int'(mc == 0 && mr == 0), "R7 frame_start",
                  int'(frame_start), int'(mc == 0 && mr == 0));
            if (!last_en && have_prev) begin
                check(int'(row) == prev_row && int'(col) == prev_col && int'(pix) == prev_pix,
                      "R5 hold on idle", int'(col), prev_col);
            end
            if (pix) begin
                ones++;
                one_r = int'(row);
                one_c = int'(col);
            end
            prev_row = int'(row); prev_col = int'(col); prev_pix = int'(pix);
            have_prev = 1;
        end
        pix_en  = en;
        rst_n   = rv;
        last_en = en;
        if (!rv) begin
            mr = 0; mc = 0; have_prev = 0;
        end else if (chk && en && pix_valid) begin
            if (mc == COLS - 1) begin
                mc = 0;
                mr = (mr + 1) % ROWS;
            end else begin
                mc++;
            end
        end
    endtask

    task automatic do_reset();
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b0);
        // R10: state after reset edges, before release
        @(negedge clk);
        check(row == '0 && col == '0, "R10 reset position", int'(col), 0);
        check(!pix_valid, "R10 pix_valid in reset", int'(pix_valid), 0);
        check(!line_start && !frame_start, "R6 R7 markers in reset", int'(frame_start), 0);
        tick(1'b0, 1'b1, 1'b0);
        // R9: pixel stream must come up within three edges
        begin
            int waited = 0;
            while (!pix_valid && waited < 5) begin
                tick(1'b0, 1'b1, 1'b0);
                waited++;
            end
            check(waited <= 3 && pix_valid, "R9 startup latency", waited, 3);
        end
        last_en = 1; have_prev = 0;
    endtask

    task automatic scan(input int n, input bit gappy);
        for (int i = 0; i < n; i++) tick(!gappy || (i % 3 != 2), 1'b1, 1'b1);
    endtask

    task automatic fill(input int p);
        for (int w = 0; w < NW; w++) begin
            case (p)
                0: mem[w] = '0;
                1: mem[w] = WW'(1) << (w % WW);
                2: mem[w] = ((w / WPR) % 2 == 1) ? '1 : '0;
                default: mem[w] = WW'(w * 40503 + 12345) ^ WW'(w << 5);
            endcase
        end
        if (p == 0) begin
            mem[0] = 16'h0001;
            mem[5] = 16'h0080;
        end
    endtask

    initial begin
        for (int p = 0; p < 4; p++) begin
            fill(p);
            do_reset();
            ones = 0;
            scan(FRAME, p % 2 == 1);
            if (p == 0) begin
                // R2: bit 7 of word 5 is row 1, column 16 + 7
                check(ones == 2, "R2 set pixel count", ones, 2);
                check(one_r == 1 && one_c == 23, "R2 LSB-first column", one_c, 23);
            end
            scan(FRAME + 5, p % 2 == 1);
        end
        // R10: reset in mid-frame with the memory changed under reset
        fill(3);
        do_reset();
        scan(100, 1'b0);
        for (int w = 0; w < NW; w++) mem[w] = ~mem[w];
        do_reset();
        check(int'(pix) == int'(mem[0][0]), "R10 first pixel after reset", int'(pix), int'(mem[0][0]));
        scan(FRAME + 40, 1'b0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule